// File: doc/BRIEF.md
# Strobe-Framed Serial Register Slave

This block is a register slave that a controller reaches over four wires: a serial clock, a data input, a data output and an active-low strobe. All four lines are asynchronous to the block. The block brings them into its fast system clock through two-flop synchronisers and finds the serial clock edges in that domain. There is no select line framing a transfer. Bits stream into a shift register on every serial clock rising edge while the strobe is high. A single rising edge taken while the strobe is low is the command clock. The data-input level on that edge picks a write (1) or a read (0).

A write frame carries 32 data bits followed by 8 address bits, each field most significant bit first. At the command clock the block takes the last 40 bits it shifted in: the upper 32 are the data and the lower 8 are the address. A read frame carries only the 8 address bits before its command clock. The block then places the register's most significant bit on the data output at once, so it is already present when the strobe goes high again. It moves to the next bit on each serial clock falling edge after the command clock, for 32 bits in all.

The register map has five addresses. 0x00 is a mode register and 0x02 is a mux-settings register; both are read/write and driven out as parallel buses. 0x80 is a reset register that drives a system-reset request. 0x08 returns a switch input bus and 0xFF returns a version input bus; both are read-only. The serial clock half-period must be at least four system clocks.

The controlling state machine has five states. SHIFT collects bits and waits for a command. WRITE commits a write for one cycle. RD_LOAD fetches the addressed word. RD_HOLD presents its MSB and waits out the command clock's falling edge. RD_SEND moves one bit per falling edge. The transitions are:
- SHIFT to WRITE on a command clock with data 1.
- SHIFT to RD_LOAD on a command clock with data 0.
- WRITE to SHIFT, and RD_LOAD to RD_HOLD, after one cycle each.
- RD_HOLD to RD_SEND on the next falling edge.
- RD_SEND to SHIFT on the falling edge that follows the 32nd data bit.

Top module: `strobe_reg_slave`

## Requirements
- R1: While reset is applied, and after it is released, the mode and mux outputs are zero, the reset request is low and the serial data output is low.
- R2: A write frame updates the addressed writable register from the last 40 bits shifted before the command clock: data in bits 39..8, address in bits 7..0. Any bits shifted earlier have no effect.
- R3: A write to address 0x08, 0xFF or any unmapped address leaves the mode output, the mux output and the reset request unchanged.
- R4: After a read command clock, the MSB of the word is on the serial output before the strobe returns high. Each later serial clock falling edge moves to the next lower bit, until all 32 bits have been sent.
- R5: Read data is as follows: 0x00 gives mode, 0x02 gives mux, 0x08 gives the switch input, 0x80 gives the last value written to the reset register, 0xFF gives the version input, and any other address gives zero.
- R6: Writing 1 to 0x80 raises the reset request. Writing 0 to 0x80 lowers it. Writing any other value leaves it unchanged.
- R7: The serial data output is low whenever no read is in progress, including after the 32nd bit of a read.
- R8: Serial clock rising edges taken with the strobe high only shift bits in. They never change a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from controller (asynchronous) |
| ser_din_i | input | 1 | Serial data from controller (asynchronous) |
| ser_stb_n_i | input | 1 | Active-low command strobe (asynchronous) |
| ser_dout_o | output | 1 | Serial read data to controller |
| mode_o | output | 32 | Mode register contents |
| mux_o | output | 32 | Mux-settings register contents |
| switch_i | input | 32 | Switch value returned at 0x08 |
| version_i | input | 32 | Version value returned at 0x FF |
| reset_req_o | output | 1 | System-reset request |

## Verification
Some properties are checked on every cycle:
- Mode and mux cannot change without a write commit.
- The reset request only rises or falls on a commit of 1 or 0 to the reset address.
- The serial output stays steady between falling edges during a read.
- A clock edge with the strobe high never leads to a write.
- Reset clears every output.

Other behaviour only the bench's frame scenarios can show. This covers the bit order and field split of whole frames, the read data for each address, the MSB appearing before the strobe rises, leading junk bits being discarded, and ignored writes to read-only and unmapped addresses.

// File: rtl/srs_pkg.sv
package srs_pkg;

    typedef enum logic [2:0] {
        ST_SHIFT   = 3'd0,
        ST_WRITE   = 3'd1,
        ST_RD_LOAD = 3'd2,
        ST_RD_HOLD = 3'd3,
        ST_RD_SEND = 3'd4
    } srs_state_e;

endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= RST_VAL;
            end
            prev_q <= RST_VAL;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign level_o = stage_q[STAGES-1];

    for (genvar b = 0; b < WIDTH; b++) begin : g_edge
        assign rise_o[b] =  stage_q[STAGES-1][b] & ~prev_q[b];
        assign fall_o[b] = ~stage_q[STAGES-1][b] &  prev_q[b];
    end

endmodule

// File: rtl/srs_frame_fsm.sv
module srs_frame_fsm
    import srs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              din_lvl,
    input  logic              stb_lvl,
    input  logic [DATA_W-1:0] rd_word,
    output srs_state_e        state_o,
    output logic              wr_en,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              dout
);

    localparam int FRAME_W = DATA_W + ADDR_W;
    localparam int CNT_W   = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    srs_state_e        state_q, state_d;
    logic [FRAME_W-1:0] frame_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  data_q;
    logic [DATA_W-1:0]  out_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               cmd_edge;

    assign cmd_edge = sck_rise & ~stb_lvl;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SHIFT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SHIFT: begin
                if (cmd_edge) begin
                    state_d = din_lvl ? ST_WRITE : ST_RD_LOAD;
                end
            end
            ST_WRITE:   state_d = ST_SHIFT;
            ST_RD_LOAD: state_d = ST_RD_HOLD;
            ST_RD_HOLD: begin
                if (sck_fall) begin
                    state_d = ST_RD_SEND;
                end
            end
            ST_RD_SEND: begin
                if (sck_fall && cnt_q == LAST_BIT) begin
                    state_d = ST_SHIFT;
                end
            end
            default:    state_d = ST_SHIFT;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            out_q   <= '0;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_SHIFT: begin
                    if (sck_rise && stb_lvl) begin
                        frame_q <= {frame_q[FRAME_W-2:0], din_lvl};
                    end
                    if (cmd_edge) begin
                        addr_q <= frame_q[ADDR_W-1:0];
                        data_q <= frame_q[FRAME_W-1:ADDR_W];
                    end
                end
                ST_RD_LOAD: begin
                    out_q <= rd_word;
                    cnt_q <= '0;
                end
                ST_RD_SEND: begin
                    if (sck_fall) begin
                        out_q <= {out_q[DATA_W-2:0], 1'b0};
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_en    = (state_q == ST_WRITE);
        dout     = (state_q == ST_RD_HOLD || state_q == ST_RD_SEND) ? out_q[DATA_W-1] : 1'b0;
        cmd_addr = addr_q;
        cmd_data = data_q;
        state_o  = state_q;
    end

endmodule

// File: rtl/srs_regfile.sv
module srs_regfile #(
    parameter int               DATA_W   = 32,
    parameter int               ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] MODE_A  = 8'h00,
    parameter logic [ADDR_W-1:0] MUX_A   = 8'h02,
    parameter logic [ADDR_W-1:0] SW_A    = 8'h08,
    parameter logic [ADDR_W-1:0] RST_A   = 8'h80,
    parameter logic [ADDR_W-1:0] VER_A   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] switch_i,
    input  logic [DATA_W-1:0] version_i,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] mode_o,
    output logic [DATA_W-1:0] mux_o,
    output logic              req_o
);

    localparam logic [DATA_W-1:0] REQ_ON  = DATA_W'(1);
    localparam logic [DATA_W-1:0] REQ_OFF = '0;

    logic [DATA_W-1:0] mode_q, mux_q, rstreg_q;
    logic              req_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            mux_q    <= '0;
            rstreg_q <= '0;
            req_q    <= 1'b0;
        end else if (wr_en) begin
            if (addr == MODE_A) mode_q <= wdata;
            if (addr == MUX_A)  mux_q  <= wdata;
            if (addr == RST_A) begin
                rstreg_q <= wdata;
                if (wdata == REQ_ON)       req_q <= 1'b1;
                else if (wdata == REQ_OFF) req_q <= 1'b0;
            end
        end
    end

    always_comb begin
        if (addr == MODE_A)     rdata = mode_q;
        else if (addr == MUX_A) rdata = mux_q;
        else if (addr == SW_A)  rdata = switch_i;
        else if (addr == RST_A) rdata = rstreg_q;
        else if (addr == VER_A) rdata = version_i;
        else                    rdata = '0;
    end

    assign mode_o = mode_q;
    assign mux_o  = mux_q;
    assign req_o  = req_q;

endmodule

// File: rtl/strobe_reg_slave.sv
module strobe_reg_slave
    import srs_pkg::*;
#(
    parameter int               DATA_W      = 32,
    parameter int               ADDR_W      = 8,
    parameter int               SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] MODE_A     = 8'h00,
    parameter logic [ADDR_W-1:0] MUX_A      = 8'h02,
    parameter logic [ADDR_W-1:0] SW_A       = 8'h08,
    parameter logic [ADDR_W-1:0] RST_A      = 8'h80,
    parameter logic [ADDR_W-1:0] VER_A      = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_din_i,
    input  logic              ser_stb_n_i,
    output logic              ser_dout_o,
    output logic [DATA_W-1:0] mode_o,
    output logic [DATA_W-1:0] mux_o,
    input  logic [DATA_W-1:0] switch_i,
    input  logic [DATA_W-1:0] version_i,
    output logic              reset_req_o
);

    // bit order of the synchroniser vector: 0 clock, 1 data, 2 strobe
    localparam int LINES = 3;

    logic [LINES-1:0]  s_lvl, s_rise, s_fall;
    logic              sck_rise, sck_fall, din_lvl, stb_lvl;
    srs_state_e        fsm_state;
    logic              wr_en;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic [DATA_W-1:0] rd_word;

    srs_sync #(
        .WIDTH   (LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_stb_n_i, ser_din_i, ser_clk_i}),
        .level_o (s_lvl),
        .rise_o  (s_rise),
        .fall_o  (s_fall)
    );

    assign sck_rise = s_rise[0];
    assign sck_fall = s_fall[0];
    assign din_lvl  = s_lvl[1];
    assign stb_lvl  = s_lvl[2];

    srs_frame_fsm #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .din_lvl  (din_lvl),
        .stb_lvl  (stb_lvl),
        .rd_word  (rd_word),
        .state_o  (fsm_state),
        .wr_en    (wr_en),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data),
        .dout     (ser_dout_o)
    );

    srs_regfile #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .MODE_A (MODE_A),
        .MUX_A  (MUX_A),
        .SW_A   (SW_A),
        .RST_A  (RST_A),
        .VER_A  (VER_A)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (cmd_addr),
        .wdata     (cmd_data),
        .switch_i  (switch_i),
        .version_i (version_i),
        .rdata     (rd_word),
        .mode_o    (mode_o),
        .mux_o     (mux_o),
        .req_o     (reset_req_o)
    );

endmodule

// File: rtl/srs_checker.sv
module srs_checker
    import srs_pkg::*;
#(
    parameter int               DATA_W = 32,
    parameter int               ADDR_W = 8,
    parameter logic [ADDR_W-1:0] RST_A = 8'h80
) (
    input logic              clk,
    input logic              rst_n,
    input srs_state_e        state,
    input logic              sck_rise,
    input logic              sck_fall,
    input logic              stb_lvl,
    input logic              wr_en,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [DATA_W-1:0] cmd_data,
    input logic              dout,
    input logic [DATA_W-1:0] mode_o,
    input logic [DATA_W-1:0] mux_o,
    input logic              req
);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (mode_o == '0 && mux_o == '0 && !req && !dout));

    a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(mode_o) && $stable(mux_o)));

    a_r6_req_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req) && $past(rst_n)) |->
            $past(wr_en && cmd_addr == RST_A && cmd_data == DATA_W'(1)));

    a_r6_req_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(req) && $past(rst_n)) |->
            $past(wr_en && cmd_addr == RST_A && cmd_data == '0));

    a_r4_dout_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_SEND && !sck_fall) |=> $stable(dout));

    a_r8_no_write_on_plain_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && sck_rise && stb_lvl) |=> !wr_en);

endmodule

bind strobe_reg_slave srs_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .RST_A  (RST_A)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (fsm_state),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .stb_lvl  (stb_lvl),
    .wr_en    (wr_en),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data),
    .dout     (ser_dout_o),
    .mode_o   (mode_o),
    .mux_o    (mux_o),
    .req      (reset_req_o)
);

// File: tb/test_strobe_reg_slave.sv
`timescale 1ns/1ps
module test_strobe_reg_slave;

    localparam int H = 8;
    localparam logic [31:0] SW_VAL  = 32'hCAFE_0808;
    localparam logic [31:0] VER_VAL = 32'h0001_0203;

    // entry layout: {write, addr[7:0], data[31:0], expected[31:0]}
    localparam int NV = 12;
    localparam logic [72:0] VEC [NV] = '{
        {1'b1, 8'h00, 32'hA5A5_0001, 32'h0},
        {1'b1, 8'h02, 32'h1234_5678, 32'h0},
        {1'b0, 8'h00, 32'h0,         32'hA5A5_0001},
        {1'b0, 8'h02, 32'h0,         32'h1234_5678},
        {1'b0, 8'h08, 32'h0,         SW_VAL},
        {1'b0, 8'hFF, 32'h0,         VER_VAL},
        {1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0},
        {1'b1, 8'hFF, 32'h0000_0000, 32'h0},
        {1'b1, 8'h55, 32'hDEAD_BEEF, 32'h0},
        {1'b0, 8'h55, 32'h0,         32'h0},
        {1'b0, 8'h00, 32'h0,         32'hA5A5_0001},
        {1'b0, 8'h02, 32'h0,         32'h1234_5678}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, din = 1'b0, stb_n = 1'b1;
    logic        dout, req;
    logic [31:0] mode, mux;
    logic [31:0] m_mode = '0, m_mux = '0, m_rst = '0;
    logic        m_req = 1'b0;
    int          checks = 0, failures = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    strobe_reg_slave i_strobe_reg_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_clk_i   (sck),
        .ser_din_i   (din),
        .ser_stb_n_i (stb_n),
        .ser_dout_o  (dout),
        .mode_o      (mode),
        .mux_o       (mux),
        .switch_i    (SW_VAL),
        .version_i   (VER_VAL),
        .reset_req_o (req)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        din = b; tick(H);
        sck = 1'b1; tick(H);
        sck = 1'b0; tick(H);
    endtask

    task automatic cmd_clock(input logic b);
        din = b; stb_n = 1'b0; tick(H);
        sck = 1'b1; tick(H);
        sck = 1'b0; tick(H);
        stb_n = 1'b1; tick(H);
    endtask

    task automatic write_frame(input logic [7:0] a, input logic [31:0] d);
        for (int i = 31; i >= 0; i--) send_bit(d[i]);
        for (int i = 7; i >= 0; i--) send_bit(a[i]);
        cmd_clock(1'b1);
        tick(H);
        case (a)
            8'h00: m_mode = d;
            8'h02: m_mux = d;
            8'h80: begin
                m_rst = d;
                if (d == 32'd1) m_req = 1'b1;
                else if (d == 32'd0) m_req = 1'b0;
            end
            default: ;
        endcase
    endtask

    task automatic read_frame(input logic [7:0] a, output logic [31:0] w,
                              output logic early, output logic after);
        for (int i = 7; i >= 0; i--) send_bit(a[i]);
        cmd_clock(1'b0);
        early = dout;
        w = '0;
        for (int i = 0; i < 32; i++) begin
            sck = 1'b1; tick(H);
            w = {w[30:0], dout};
            sck = 1'b0; tick(H);
        end
        tick(H);
        after = dout;
    endtask

    task automatic check_state(input string tag);
        check(mode == m_mode, tag, mode, m_mode);
        check(mux == m_mux, tag, mux, m_mux);
        check(req == m_req, tag, {31'b0, req}, {31'b0, m_req});
    endtask

    initial begin
        logic [31:0] w;
        logic        early, after;

        tick(6);
        check(mode == 0 && mux == 0, "R1 reset regs", mode | mux, 32'h0);
        check(!req && !dout, "R1 reset req/dout", {30'b0, req, dout}, 32'h0);
        rst_n = 1'b1;
        tick(4);
        check_state("R1 after release");

        for (int i = 0; i < NV; i++) begin
            logic [72:0] v;
            v = VEC[i];
            if (v[72]) begin
                write_frame(v[71:64], v[63:32]);
                if (v[71:64] == 8'h00 || v[71:64] == 8'h02)
                    check_state("R2 write");
                else
                    check_state("R3 ignored write");
            end else begin
                read_frame(v[71:64], w, early, after);
                check(w == v[31:0], "R5 read data", w, v[31:0]);
                check(after == 1'b0, "R7 dout idle after read", {31'b0, after}, 32'h0);
            end
        end

        // R4: MSB present before strobe returns high
        read_frame(8'h00, w, early, after);
        check(early == m_mode[31], "R4 MSB before strobe high", {31'b0, early}, {31'b0, m_mode[31]});
        check(w == m_mode, "R4 bit sequence", w, m_mode);
        read_frame(8'h02, w, early, after);
        check(early == m_mux[31], "R4 MSB early low case", {31'b0, early}, {31'b0, m_mux[31]});

        // R2: leading junk bits discarded
        for (int i = 0; i < 7; i++) send_bit(i[0]);
        write_frame(8'h02, 32'h0F0F_F0F0);
        check_state("R2 leading bits");

        // R8: free-running clocks with strobe high
        for (int i = 0; i < 20; i++) send_bit(~i[1]);
        check_state("R8 plain clocks");
        check(dout == 1'b0, "R7 dout idle", {31'b0, dout}, 32'h0);

        // R6: reset request set/hold/clear
        write_frame(8'h80, 32'd1);
        check(req == 1'b1, "R6 request set", {31'b0, req}, 32'h1);
        write_frame(8'h80, 32'd5);
        check(req == 1'b1, "R6 request held", {31'b0, req}, 32'h1);
        read_frame(8'h80, w, early, after);
        check(w == 32'd5, "R5 reset reg readback", w, 32'd5);
        write_frame(8'h80, 32'd0);
        check(req == 1'b0, "R6 request cleared", {31'b0, req}, 32'h0);
        write_frame(8'h80, 32'd1);
        check(req == 1'b1, "R6 request set again", {31'b0, req}, 32'h1);

        // R1: mid-run reset
        rst_n = 1'b0; tick(4);
        check(!req && mode == 0 && mux == 0, "R1 mid-run reset", {31'b0, req} | mode | mux, 32'h0);
        rst_n = 1'b1; tick(4);
        m_mode = '0; m_mux = '0; m_req = 1'b0; m_rst = '0;
        read_frame(8'h80, w, early, after);
        check(w == 32'd0, "R1 reset reg cleared", w, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule